// File: doc/BRIEF.md
# Encoded Signed-Digit Shift Multiply-Accumulate

This block is one multiply-accumulate step for a processing element whose weights are stored as short codes. Each code stands for a sum of one to three signed powers of two. The block never multiplies. Each digit of the code selects a shift count from a short list fixed at elaboration, and the activation is shifted by that count in a shifter of its own. The shifted terms are negated where the digit is negative and then added to an incoming partial sum. The result is written into an output register.

The activation is a plain two's-complement fixed-point number. The partial sum arrives from a neighbouring cell, or is fed back from the output. The accumulator width is derived from the activation width, the largest allowed shift, the digit count and a declared maximum accumulation length. A run of that length therefore cannot wrap. The defaults give three digits and an 8-bit weight code:

- Digit 0 is signed, with 8 shifts.
- Digit 1 is signed, with 4 shifts.
- Digit 2 is unsigned, with 2 shifts.

Top module: `sd_shift_mac`

## Requirements
- R1: The weight code is split into consecutive groups, digit 0 in the least significant group. Each group holds its index field in the low bits, with the sign bit, if present, directly above it. With the defaults: bits [2:0] hold the digit-0 index and bit 3 its sign. Bits [5:4] hold the digit-1 index and bit 6 its sign. Bit 7 holds the digit-2 index.
- R2: The index selects a shift count from that digit's fixed list. The default lists are 0..7 for digit 0, 0..3 for digit 1, and {0, 4} for digit 2. An index past the end of a list selects its last entry.
- R3: On an update, psum_out becomes psum_in plus the sum, over all digits, of (±1) × act × 2^shift. The result is exact modulo 2^ACC_W, and act is read as two's complement.
- R4: A digit whose sign bit is 1 subtracts its shifted activation. A sign bit of 0 adds it.
- R5: A digit declared unsigned has no sign bit and always adds its term.
- R6: When valid is low and clr is low, psum_out holds its value whatever the other inputs do.
- R7: A high clr sets psum_out to zero on the next edge and takes priority over valid.
- R8: A high rst sets psum_out to zero on the next edge and takes priority over clr and valid.
- R9: Feeding psum_out back to psum_in for MAX_ACC_LEN updates with extreme operands never wraps. The result equals the exact integer sum. The default ACC_W is 21 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the accumulator |
| valid | input | 1 | Update strobe |
| weight | input | W_W | Encoded signed-digit weight |
| act | input | ACT_W | Two's-complement activation |
| psum_in | input | ACC_W | Incoming partial sum |
| psum_out | output | ACC_W | Registered partial sum |

## Verification
A wrong shift-table entry, a swapped field boundary or a lost carry-in shows on psum_out one edge after a valid cycle. It appears as a value off by a power-of-two multiple of the activation, or by exactly one for each negative digit. A register that updates on the wrong strobe shows as a changed output in the cycle after a held or cleared cycle. A sign-extension or width error appears only with large negative activations over a long feedback run. That fault surfaces at the end of the run, as a wrapped sum.

// File: rtl/sd_mac_pkg.sv
package sd_mac_pkg;
  localparam int MAX_DIGITS = 3;
  localparam int MAX_SHIFTS = 8;
  localparam int SH_W       = 4;

  typedef logic [MAX_DIGITS-1:0][3:0] nshift_vec_t;
  typedef logic [MAX_SHIFTS-1:0][SH_W-1:0] shift_list_t;
  typedef logic [MAX_DIGITS-1:0][MAX_SHIFTS-1:0][SH_W-1:0] shift_tab_t;

  // index bits for a list of n shift counts (at least one bit)
  function automatic int idx_bits(int n);
    if (n <= 2) return 1;
    return $clog2(n);
  endfunction

  function automatic int grp_bits(nshift_vec_t ns, logic [MAX_DIGITS-1:0] sg, int k);
    return idx_bits(int'(ns[k])) + (sg[k] ? 1 : 0);
  endfunction

  function automatic int grp_lsb(nshift_vec_t ns, logic [MAX_DIGITS-1:0] sg, int k);
    int pos;
    pos = 0;
    for (int j = 0; j < k; j++) pos += grp_bits(ns, sg, j);
    return pos;
  endfunction

  function automatic int max_shift(shift_tab_t tab, nshift_vec_t ns, int nd);
    int m;
    m = 0;
    for (int k = 0; k < nd; k++)
      for (int i = 0; i < MAX_SHIFTS; i++)
        if (i < int'(ns[k]) && int'(tab[k][i]) > m) m = int'(tab[k][i]);
    return m;
  endfunction
endpackage

// File: rtl/sd_digit_decode.sv
module sd_digit_decode #(
  parameter int IDX_W    = 3,
  parameter bit HAS_SIGN = 1'b1,
  parameter int NSH      = 8,
  parameter sd_mac_pkg::shift_list_t TAB = '0,
  localparam int GRP_W   = IDX_W + (HAS_SIGN ? 1 : 0)
) (
  input  logic [GRP_W-1:0]            field,
  output logic                        neg,
  output logic [sd_mac_pkg::SH_W-1:0] shamt
);
  logic [IDX_W-1:0] idx;
  assign idx = field[IDX_W-1:0];

  generate
    if (HAS_SIGN) begin : g_signed
      assign neg = field[GRP_W-1];
    end else begin : g_unsigned
      assign neg = 1'b0;
    end
  endgenerate

  always_comb begin
    if (32'(idx) < NSH) shamt = TAB[idx];
    else                shamt = TAB[NSH-1];
  end
endmodule

// File: rtl/sd_digit_shift.sv
module sd_digit_shift #(
  parameter int ACT_W = 8,
  parameter int ACC_W = 21
) (
  input  logic [ACT_W-1:0]            act,
  input  logic [sd_mac_pkg::SH_W-1:0] shamt,
  input  logic                        neg,
  output logic [ACC_W-1:0]            term
);
  logic [ACC_W-1:0] ext;
  logic [ACC_W-1:0] shifted;

  assign ext     = {{(ACC_W-ACT_W){act[ACT_W-1]}}, act};
  assign shifted = ext << shamt;
  // the +1 that completes the negation enters the reduction separately
  assign term    = neg ? ~shifted : shifted;
endmodule

// File: rtl/sd_csa_reduce.sv
module sd_csa_reduce #(
  parameter int ACC_W = 21,
  parameter int N_OPS = 5
) (
  input  logic [N_OPS-1:0][ACC_W-1:0] ops,
  output logic [ACC_W-1:0]            sum
);
  logic [ACC_W-1:0] s_row;
  logic [ACC_W-1:0] c_row;
  logic [ACC_W-1:0] s_nxt;

  always_comb begin
    s_row = ops[0];
    c_row = ops[1];
    for (int i = 2; i < N_OPS; i++) begin
      s_nxt = s_row ^ c_row ^ ops[i];
      c_row = ((s_row & c_row) | (s_row & ops[i]) | (c_row & ops[i])) << 1;
      s_row = s_nxt;
    end
    sum = s_row + c_row;
  end
endmodule

// File: rtl/sd_shift_mac.sv
module sd_shift_mac #(
  parameter int ACT_W       = 8,
  parameter int NUM_DIGITS  = 3,
  parameter int MAX_ACC_LEN = 16,
  parameter logic [sd_mac_pkg::MAX_DIGITS-1:0] DIG_SIGNED = 3'b011,
  parameter sd_mac_pkg::nshift_vec_t DIG_NSHIFT = {4'd2, 4'd4, 4'd8},
  parameter sd_mac_pkg::shift_tab_t  SHIFT_TAB  = 96'h00000040_00003210_76543210,
  localparam int W_W   = sd_mac_pkg::grp_lsb(DIG_NSHIFT, DIG_SIGNED, NUM_DIGITS),
  localparam int MAX_SH = sd_mac_pkg::max_shift(SHIFT_TAB, DIG_NSHIFT, NUM_DIGITS),
  localparam int ACC_W = ACT_W + MAX_SH + $clog2(NUM_DIGITS + 1) + $clog2(MAX_ACC_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             valid,
  input  logic [W_W-1:0]   weight,
  input  logic [ACT_W-1:0] act,
  input  logic [ACC_W-1:0] psum_in,
  output logic [ACC_W-1:0] psum_out
);
  localparam int N_OPS = NUM_DIGITS + 2;

  logic [NUM_DIGITS-1:0]             neg;
  logic [N_OPS-1:0][ACC_W-1:0]       ops;
  logic [ACC_W-1:0]                  neg_cnt;
  logic [ACC_W-1:0]                  sum;

  generate
    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
      localparam int IW  = sd_mac_pkg::idx_bits(int'(DIG_NSHIFT[k]));
      localparam int GW  = sd_mac_pkg::grp_bits(DIG_NSHIFT, DIG_SIGNED, k);
      localparam int LSB = sd_mac_pkg::grp_lsb(DIG_NSHIFT, DIG_SIGNED, k);
      logic [sd_mac_pkg::SH_W-1:0] shamt;

      sd_digit_decode #(
        .IDX_W(IW), .HAS_SIGN(DIG_SIGNED[k]),
        .NSH(int'(DIG_NSHIFT[k])), .TAB(SHIFT_TAB[k])
      ) u_dec (
        .field(weight[LSB +: GW]), .neg(neg[k]), .shamt(shamt)
      );

      sd_digit_shift #(.ACT_W(ACT_W), .ACC_W(ACC_W)) u_sh (
        .act(act), .shamt(shamt), .neg(neg[k]), .term(ops[k])
      );
    end
  endgenerate

  // one +1 per negated digit completes the two's-complement negation
  always_comb begin
    neg_cnt = '0;
    for (int k = 0; k < NUM_DIGITS; k++)
      neg_cnt = neg_cnt + {{(ACC_W-1){1'b0}}, neg[k]};
  end

  assign ops[NUM_DIGITS]   = psum_in;
  assign ops[NUM_DIGITS+1] = neg_cnt;

  sd_csa_reduce #(.ACC_W(ACC_W), .N_OPS(N_OPS)) u_red (
    .ops(ops), .sum(sum)
  );

  always_ff @(posedge clk) begin
    if (rst || clr)  psum_out <= '0;
    else if (valid)  psum_out <= sum;
  end
endmodule

// File: rtl/sd_shift_mac_chk.sv
module sd_shift_mac_chk #(
  parameter int ACT_W      = 8,
  parameter int NUM_DIGITS = 3,
  parameter logic [sd_mac_pkg::MAX_DIGITS-1:0] DIG_SIGNED = 3'b011,
  parameter sd_mac_pkg::nshift_vec_t DIG_NSHIFT = {4'd2, 4'd4, 4'd8},
  parameter sd_mac_pkg::shift_tab_t  SHIFT_TAB  = 96'h00000040_00003210_76543210,
  parameter int W_W   = 8,
  parameter int ACC_W = 21
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             valid,
  input logic [W_W-1:0]   weight,
  input logic [ACT_W-1:0] act,
  input logic [ACC_W-1:0] psum_in,
  input logic [ACC_W-1:0] psum_out
);
  logic [ACC_W-1:0] ref_sum;

  // arithmetic model: signed digit value times activation, by multiplication
  always_comb begin
    longint total;
    longint a;
    int lsb, iw, idx, ns;
    logic [31:0] fld;
    logic n;
    a = longint'($signed(act));
    total = longint'($signed(psum_in));
    for (int k = 0; k < NUM_DIGITS; k++) begin
      lsb = sd_mac_pkg::grp_lsb(DIG_NSHIFT, DIG_SIGNED, k);
      iw  = sd_mac_pkg::idx_bits(int'(DIG_NSHIFT[k]));
      ns  = int'(DIG_NSHIFT[k]);
      fld = 32'(weight) >> lsb;
      idx = int'(fld & ((32'd1 << iw) - 32'd1));
      if (idx >= ns) idx = ns - 1;
      n = DIG_SIGNED[k] ? fld[iw] : 1'b0;
      if (n) total = total - a * (64'sd1 << SHIFT_TAB[k][idx]);
      else   total = total + a * (64'sd1 << SHIFT_TAB[k][idx]);
    end
    ref_sum = total[ACC_W-1:0];
  end

  p_reset_zero_r8: assert property (@(posedge clk) rst |=> psum_out == '0);

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> psum_out == '0);

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!valid && !clr) |=> $stable(psum_out));

  p_exact_sum_r3: assert property (@(posedge clk) disable iff (rst)
    (valid && !clr) |=> psum_out == $past(ref_sum));
endmodule

bind sd_shift_mac sd_shift_mac_chk #(
  .ACT_W(ACT_W), .NUM_DIGITS(NUM_DIGITS), .DIG_SIGNED(DIG_SIGNED),
  .DIG_NSHIFT(DIG_NSHIFT), .SHIFT_TAB(SHIFT_TAB), .W_W(W_W), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .valid(valid), .weight(weight),
  .act(act), .psum_in(psum_in), .psum_out(psum_out)
);

// File: tb/tb_sd_shift_mac.sv
module tb_sd_shift_mac;
  localparam int WW = 8;   // default weight code width
  localparam int AW = 8;
  localparam int CW = 21;  // 8 + 7 + 2 + 4

  typedef struct packed {
    logic [WW-1:0]        w;
    logic signed [AW-1:0] a;
    logic signed [CW-1:0] p;
    logic signed [CW-1:0] e;
  } vec_t;

  // code bits: [2:0] idx0, [3] sign0, [5:4] idx1, [6] sign1, [7] idx2
  localparam vec_t VECS [8] = '{
    '{8'h00,  8'sd5,    21'sd0,     21'sd15},     // R1 R2: all +1 digits
    '{8'hBF,  8'sd3,    21'sd100,  -21'sd212},    // R4: -128+8+16
    '{8'h52, -8'sd128,  21'sd0,    -21'sd384},    // R4: 4-2+1
    '{8'hB7, -8'sd128, -21'sd1000, -21'sd20456},  // R2: 128+8+16
    '{8'h48,  8'sd127,  21'sd7,    -21'sd120},    // R5: -1-1+1
    '{8'hED, -8'sd7,   -21'sd40,    21'sd100},    // R4 R5: -32-4+16
    '{8'h73, -8'sd1,    21'sd0,    -21'sd1},      // R3: 8-8+1
    '{8'hBF,  8'sd0,    21'sd12345, 21'sd12345}   // R3: zero activation
  };

  logic clk = 1'b0;
  logic rst, clr, valid;
  logic [WW-1:0] weight;
  logic [AW-1:0] act;
  logic [CW-1:0] psum_in;
  logic [CW-1:0] psum_out;
  int n_checks = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  sd_shift_mac dut (
    .clk(clk), .rst(rst), .clr(clr), .valid(valid), .weight(weight),
    .act(act), .psum_in(psum_in), .psum_out(psum_out)
  );

  task automatic check(input string req, input logic [CW-1:0] got, input logic [CW-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, $signed(got), $signed(exp));
    end
  endtask

  task automatic drive(input logic v, input logic c, input logic [WW-1:0] w,
                       input logic [AW-1:0] a, input logic [CW-1:0] p);
    valid = v; clr = c; weight = w; act = a; psum_in = p;
    @(negedge clk);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_checks++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] held;
    longint ref_acc;
    rst = 1'b1; clr = 1'b0; valid = 1'b1;
    weight = 8'hB7; act = 8'sd100; psum_in = 21'sd5;
    @(negedge clk); @(negedge clk);
    check("R8 reset state", psum_out, '0);
    rst = 1'b0;

    for (int i = 0; i < 8; i++) begin
      drive(1'b1, 1'b0, VECS[i].w, VECS[i].a, VECS[i].p);
      check($sformatf("R3 vector %0d", i), psum_out, VECS[i].e);
    end

    // R6: idle cycles with changing inputs leave the output alone
    held = psum_out;
    drive(1'b0, 1'b0, 8'hB7, -8'sd128, 21'sd777);
    drive(1'b0, 1'b0, 8'h00, 8'sd1, -21'sd3);
    check("R6 hold while idle", psum_out, held);

    // R7: clear wins over valid
    drive(1'b1, 1'b1, 8'hB7, 8'sd50, 21'sd9);
    check("R7 clear over valid", psum_out, '0);
    drive(1'b1, 1'b0, 8'h00, 8'sd2, 21'sd1);
    check("R3 after clear", psum_out, 21'sd7);
    drive(1'b0, 1'b1, 8'h00, 8'sd2, 21'sd1);
    check("R7 clear alone", psum_out, '0);

    // R9: longest run with the largest negative term, fed back
    ref_acc = 0;
    for (int i = 0; i < 16; i++) begin
      drive(1'b1, 1'b0, 8'hB7, -8'sd128, psum_out);
      ref_acc += -128 * 152;
    end
    check("R9 negative run", psum_out, ref_acc[CW-1:0]);
    drive(1'b0, 1'b1, 8'h00, 8'sd0, '0);
    ref_acc = 0;
    for (int i = 0; i < 16; i++) begin
      drive(1'b1, 1'b0, 8'hB7, 8'sd127, psum_out);
      ref_acc += 127 * 152;
    end
    check("R9 positive run", psum_out, ref_acc[CW-1:0]);

    // R8: reset wins over valid mid-run
    rst = 1'b1;
    drive(1'b1, 1'b0, 8'hB7, 8'sd127, psum_out);
    check("R8 reset over valid", psum_out, '0);
    rst = 1'b0;
    // R2 R4: digit 0 alone at its extremes (digits 1,2 give +1 each: 1+1)
    drive(1'b1, 1'b0, 8'h0F, 8'sd1, 21'sd0);
    check("R4 digit0 -128", psum_out, -21'sd126);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule